// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block keeps the frame timing of a time-division-multiplexed audio port. It advances a bit-position counter once per bit clock. The bit clock arrives as a single-cycle enable pulse, `bitEn`, from a divider outside the block. For the serializers behind it, the block reports the current bit position, a frame-start strobe and a slot-start strobe.

As master, the block also drives the frame sync pin. The sync can take one of three shapes:
- a one-bit pulse on the first bit of the frame (short, late);
- a one-bit pulse on the last bit of the previous frame (short, early);
- a level held for one whole slot at the head of the frame (long).

As slave, the sync output stays low. The block instead locks its counter to rising edges of the incoming sync.

A combinational checker raises `cfgErr` when the programmed frame is too short for the slots it must carry. The frame length is `frameDiv + 1` bit clocks. It is normally set to the bit clock rate divided by the sample rate.

Top module: `tdm_frame_sync`

## Requirements
- R1: With `ctrlBits[0]=1`, each `bitEn` cycle has a bit position `bitCnt`. It runs 0, 1, …, `frameDiv` and then returns to 0, so a frame is `frameDiv+1` bit clocks long. `frameStart` is high in a reported `bitEn` cycle whose bit position is 0.
- R2: The slot length is the larger of `slotLenTx` and `slotLenRx`. `slotStart` is high in every reported `bitEn` cycle whose position inside its slot is 0. The slot position restarts at every frame start, so `frameStart` always comes with `slotStart`.
- R3: In master mode (`ctrlBits[1]=0`) with short sync (`ctrlBits[2]=0`) and late placement (`ctrlBits[3]=0`), `syncOut` is high during bit 0 only.
- R4: In master mode with short sync and early placement (`ctrlBits[3]=1`), `syncOut` is high during bit `frameDiv` only.
- R5: In master mode with long sync (`ctrlBits[2]=1`), `syncOut` is high during bits 0 to slot length − 1. `ctrlBits[3]` has no effect in this mode.
- R6: `cfgErr` is high when `frameDiv+1` is less than max(`slotLenTx`,`slotLenRx`) × max(`slotCntTx`,`slotCntRx`).
- R7: `cfgErr` is also high when all three of these hold:
  - long sync is selected;
  - `slotCntTx ≤ 1` or `slotCntRx ≤ 1`;
  - `frameDiv+1` ≤ the slot length.
- R8: While `ctrlBits[0]=0`, `bitCnt` is 0, `syncOut` is low and no strobe fires. After enable, the first `bitEn` is bit 0.
- R9: In slave mode (`ctrlBits[1]=1`), `syncOut` stays low. No strobe fires until the first rising edge of `syncIn` has been seen since enable.
- R10: In slave mode with late or long placement, a `bitEn` cycle in which `syncIn` is high, when it was low at the previous `bitEn`, becomes bit 0. That cycle reports `bitCnt=0` and `frameStart`, and counting continues from it.
- R11: In slave mode with short early placement, the rising-edge bit is the last bit of a frame. The next `bitEn` is bit 0 and carries `frameStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | One-cycle bit clock enable |
| ctrlBits | input | 4 | [0] enable, [1] slave, [2] long sync, [3] early short sync |
| frameDiv | input | DIV_W | Frame length minus one, in bit clocks |
| slotLenTx | input | SL_W | Transmit slot length in bit clocks |
| slotLenRx | input | SL_W | Receive slot length in bit clocks |
| slotCntTx | input | SC_W | Transmit slots per frame |
| slotCntRx | input | SC_W | Receive slots per frame |
| syncIn | input | 1 | External frame sync (slave mode) |
| syncOut | output | 1 | Driven frame sync (master mode) |
| frameStart | output | 1 | Strobe on bit 0 of a frame |
| slotStart | output | 1 | Strobe on bit 0 of a slot |
| bitCnt | output | DIV_W | Current bit position in the frame |
| cfgErr | output | 1 | Illegal frame configuration |

## Verification
In slave mode, the natural wrap of the counter to bit 0 and a resynchronising `syncIn` edge can fall on the same `bitEn`. The bench drives a rising sync exactly on the bit where the counter wraps. It expects one `frameStart`, `bitCnt=0` and a coinciding `slotStart`, followed by bit 1 on the next pulse with no second strobe. A mid-frame edge is also driven, and must restart the count at 0 on that same bit.

// File: rtl/tdmfs_pkg.sv
package tdmfs_pkg;
  typedef struct packed {
    logic clear;     // hold counters at zero
    logic step;      // advance counters this cycle
    logic zeroNow;   // current bit is bit 0 (late resync)
    logic zeroNext;  // next bit is bit 0 (early resync)
    logic report;    // strobes may be shown this cycle
  } tdmfs_cmd_t;
endpackage

// File: rtl/tdmfs_ctrl.sv
module tdmfs_ctrl
  import tdmfs_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int SL_W  = 6,
  parameter int SC_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic [3:0]       ctrlBits,
  input  logic [DIV_W-1:0] frameDiv,
  input  logic [SL_W-1:0]  slotLenTx,
  input  logic [SL_W-1:0]  slotLenRx,
  input  logic [SC_W-1:0]  slotCntTx,
  input  logic [SC_W-1:0]  slotCntRx,
  input  logic             syncIn,
  output tdmfs_cmd_t       cmd,
  output logic [SL_W-1:0]  slotLen,
  output logic             drive,
  output logic             longSync,
  output logic             early,
  output logic             cfgErr
);
  localparam int PW = (DIV_W + 1 > SL_W + SC_W) ? DIV_W + 1 : SL_W + SC_W;

  logic enable, slave;
  logic syncPrev, locked, riseNow;
  logic [SC_W-1:0] slotCnt;
  logic [PW-1:0] frameLenW, needW, slotLenW;
  logic shortOfSlots, oneSlot, longTooShort;

  assign enable   = ctrlBits[0];
  assign slave    = ctrlBits[1];
  assign longSync = ctrlBits[2];
  assign early    = ctrlBits[3];
  assign drive    = enable && !slave;

  assign slotLen = (slotLenRx >= slotLenTx) ? slotLenRx : slotLenTx;
  assign slotCnt = (slotCntRx >= slotCntTx) ? slotCntRx : slotCntTx;

  assign riseNow = bitEn && syncIn && !syncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      locked   <= 1'b0;
    end else if (!enable) begin
      syncPrev <= 1'b0;
      locked   <= 1'b0;
    end else if (bitEn) begin
      syncPrev <= syncIn;
      if (!slave)
        locked <= 1'b0;
      else if (riseNow)
        locked <= 1'b1;
    end
  end

  always_comb begin
    cmd.clear    = !enable;
    cmd.step     = enable && bitEn;
    cmd.zeroNow  = enable && slave && riseNow && !(early && !longSync);
    cmd.zeroNext = enable && slave && riseNow && early && !longSync;
    cmd.report   = enable && bitEn && (!slave || locked || cmd.zeroNow);
  end

  assign frameLenW    = PW'(frameDiv) + PW'(1);
  assign slotLenW     = PW'(slotLen);
  assign needW        = PW'(slotLen) * PW'(slotCnt);
  assign shortOfSlots = frameLenW < needW;
  assign oneSlot      = (slotCntTx <= SC_W'(1)) || (slotCntRx <= SC_W'(1));
  assign longTooShort = longSync && oneSlot && (frameLenW <= slotLenW);
  assign cfgErr       = shortOfSlots || longTooShort;

  AST_SLAVE_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && slave && !locked && !riseNow) |-> !cmd.report) else $error("R9 strobe before lock"); // R9

endmodule

// File: rtl/tdmfs_dp.sv
module tdmfs_dp
  import tdmfs_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int SL_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  tdmfs_cmd_t       cmd,
  input  logic [DIV_W-1:0] frameDiv,
  input  logic [SL_W-1:0]  slotLen,
  input  logic             drive,
  input  logic             longSync,
  input  logic             early,
  output logic [DIV_W-1:0] bitCnt,
  output logic             frameStart,
  output logic             slotStart,
  output logic             syncOut
);
  localparam int CW = (DIV_W > SL_W) ? DIV_W : SL_W;

  logic [DIV_W-1:0] bitReg, curBit, nextBit;
  logic [SL_W-1:0]  slotReg, curSlot, nextSlot;
  logic [SL_W:0]    slotInc;
  logic [CW-1:0]    bitW, slotW;

  assign curBit  = cmd.zeroNow ? '0 : bitReg;
  assign curSlot = (curBit == '0) ? '0 : slotReg;
  assign nextBit = (cmd.zeroNext || curBit >= frameDiv) ? '0 : curBit + DIV_W'(1);
  assign slotInc = {1'b0, curSlot} + (SL_W+1)'(1);

  always_comb begin
    if (nextBit == '0)
      nextSlot = '0;
    else if (slotInc >= {1'b0, slotLen})
      nextSlot = '0;
    else
      nextSlot = slotInc[SL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitReg  <= '0;
      slotReg <= '0;
    end else if (cmd.clear) begin
      bitReg  <= '0;
      slotReg <= '0;
    end else if (cmd.step) begin
      bitReg  <= nextBit;
      slotReg <= nextSlot;
    end
  end

  assign bitW  = CW'(bitReg);
  assign slotW = CW'(slotLen);

  always_comb begin
    if (!drive)
      syncOut = 1'b0;
    else if (longSync)
      syncOut = bitW < slotW;
    else if (early)
      syncOut = bitReg == frameDiv;
    else
      syncOut = bitReg == '0;
  end

  assign bitCnt     = curBit;
  assign frameStart = cmd.report && (curBit == '0);
  assign slotStart  = cmd.report && (curSlot == '0);

  AST_FRAME_HAS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> slotStart) else $error("R2 frame without slot"); // R2

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.zeroNext && curBit == frameDiv) |=> (bitReg == '0)) else $error("R1 no wrap"); // R1

  AST_SHORT_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && syncOut && !longSync && frameDiv != '0) |=>
      (!syncOut || !$stable(frameDiv) || !$stable(longSync) || !$stable(early) || !$stable(drive)))
    else $error("R3 short sync too wide"); // R3

endmodule

// File: rtl/tdm_frame_sync.sv
module tdm_frame_sync
  import tdmfs_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int SL_W  = 6,
  parameter int SC_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic [3:0]       ctrlBits,
  input  logic [DIV_W-1:0] frameDiv,
  input  logic [SL_W-1:0]  slotLenTx,
  input  logic [SL_W-1:0]  slotLenRx,
  input  logic [SC_W-1:0]  slotCntTx,
  input  logic [SC_W-1:0]  slotCntRx,
  input  logic             syncIn,
  output logic             syncOut,
  output logic             frameStart,
  output logic             slotStart,
  output logic [DIV_W-1:0] bitCnt,
  output logic             cfgErr
);
  tdmfs_cmd_t      cmd;
  logic [SL_W-1:0] slotLen;
  logic            drive, longSync, early;

  tdmfs_ctrl #(.DIV_W(DIV_W), .SL_W(SL_W), .SC_W(SC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .ctrlBits(ctrlBits),
    .frameDiv(frameDiv), .slotLenTx(slotLenTx), .slotLenRx(slotLenRx),
    .slotCntTx(slotCntTx), .slotCntRx(slotCntRx), .syncIn(syncIn),
    .cmd(cmd), .slotLen(slotLen), .drive(drive), .longSync(longSync),
    .early(early), .cfgErr(cfgErr)
  );

  tdmfs_dp #(.DIV_W(DIV_W), .SL_W(SL_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .frameDiv(frameDiv),
    .slotLen(slotLen), .drive(drive), .longSync(longSync), .early(early),
    .bitCnt(bitCnt), .frameStart(frameStart), .slotStart(slotStart),
    .syncOut(syncOut)
  );

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBits[1] |-> !syncOut) else $error("R9 slave drives sync"); // R9

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[0] |=> (bitCnt == '0)) else $error("R8 counter not cleared"); // R8

endmodule

// File: tb/test_tdm_frame_sync.sv
module test_tdm_frame_sync;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 10;
  localparam int SL_W  = 6;
  localparam int SC_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic [3:0] ctrlBits = '0;
  logic [DIV_W-1:0] frameDiv = '0;
  logic [SL_W-1:0] slotLenTx = '0, slotLenRx = '0;
  logic [SC_W-1:0] slotCntTx = '0, slotCntRx = '0;
  logic syncIn = 1'b0;
  logic syncOut, frameStart, slotStart, cfgErr;
  logic [DIV_W-1:0] bitCnt;

  int errors = 0;
  int checks = 0;
  logic sFs, sSs, sSync;
  int sCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_frame_sync #(.DIV_W(DIV_W), .SL_W(SL_W), .SC_W(SC_W)) i_tdm_frame_sync (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .ctrlBits(ctrlBits),
    .frameDiv(frameDiv), .slotLenTx(slotLenTx), .slotLenRx(slotLenRx),
    .slotCntTx(slotCntTx), .slotCntRx(slotCntRx), .syncIn(syncIn),
    .syncOut(syncOut), .frameStart(frameStart), .slotStart(slotStart),
    .bitCnt(bitCnt), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doBit(input logic s);
    @(negedge clk);
    syncIn = s;
    bitEn  = 1'b1;
    #1;
    sFs = frameStart; sSs = slotStart; sSync = syncOut; sCnt = int'(bitCnt);
    @(negedge clk);
    bitEn = 1'b0;
  endtask

  task automatic restart(input logic [3:0] c);
    @(negedge clk);
    ctrlBits = 4'b0000;
    syncIn = 1'b0;
    repeat (2) @(negedge clk);
    ctrlBits = c;
  endtask

  task automatic setCfg(input int d, input int lt, input int lr, input int ct, input int cr);
    frameDiv = DIV_W'(d); slotLenTx = SL_W'(lt); slotLenRx = SL_W'(lr);
    slotCntTx = SC_W'(ct); slotCntRx = SC_W'(cr);
  endtask

  task automatic t_reset();
    #1;
    check("R8 reset bitCnt", int'(bitCnt), 0);
    check("R8 reset syncOut", int'(syncOut), 0);
    check("R8 reset frameStart", int'(frameStart), 0);
  endtask

  // mode: 0 short late, 1 short early, 2 long
  task automatic t_master(input logic [3:0] c, input int d, input int slot, input int mode,
                          input int nbits, input string reqSync);
    restart(c);
    for (int i = 0; i < nbits; i++) begin
      int p;
      int es;
      p = i % (d + 1);
      es = (mode == 0) ? int'(p == 0) : (mode == 1) ? int'(p == d) : int'(p < slot);
      doBit(1'b0);
      check("R1 bitCnt", sCnt, p);
      check("R1 frameStart", int'(sFs), int'(p == 0));
      check("R2 slotStart", int'(sSs), int'((p % slot) == 0));
      check(reqSync, int'(sSync), es);
    end
  endtask

  task automatic t_disable();
    setCfg(15, 8, 8, 2, 2);
    restart(4'b0001);
    repeat (5) doBit(1'b0);
    @(negedge clk);
    ctrlBits = 4'b0000;
    doBit(1'b0);
    check("R8 disabled bitCnt", sCnt, 0);
    check("R8 disabled frameStart", int'(sFs), 0);
    check("R8 disabled slotStart", int'(sSs), 0);
    check("R8 disabled syncOut", int'(sSync), 0);
    @(negedge clk);
    ctrlBits = 4'b0001;
    doBit(1'b0);
    check("R8 restart bit0", sCnt, 0);
    check("R8 restart frameStart", int'(sFs), 1);
    doBit(1'b0);
    check("R8 restart bit1", sCnt, 1);
  endtask

  task automatic t_cfg();
    setCfg(15, 8, 4, 2, 1);  #1; check("R6 exact fit", int'(cfgErr), 0);
    setCfg(14, 8, 4, 2, 1);  #1; check("R6 one short", int'(cfgErr), 1);
    setCfg(15, 4, 8, 1, 2);  #1; check("R6 max from rx", int'(cfgErr), 0);
    setCfg(14, 4, 8, 1, 2);  #1; check("R6 max from rx short", int'(cfgErr), 1);
    ctrlBits = 4'b0100;
    setCfg(15, 16, 8, 1, 1); #1; check("R7 long equal", int'(cfgErr), 1);
    setCfg(16, 16, 8, 1, 1); #1; check("R7 long longer", int'(cfgErr), 0);
    ctrlBits = 4'b0000;
    setCfg(15, 16, 8, 1, 1); #1; check("R7 short mode exempt", int'(cfgErr), 0);
  endtask

  task automatic slaveBit(input logic s, input int fs, input int cnt, input string req);
    doBit(s);
    check(req, int'(sFs), fs);
    if (cnt >= 0) check(req, sCnt, cnt);
    check("R9 slave syncOut low", int'(sSync), 0);
  endtask

  task automatic t_slaveLate();
    setCfg(15, 8, 8, 2, 2);
    restart(4'b0011);
    for (int i = 0; i < 5; i++) begin
      doBit(1'b0);
      check("R9 no frameStart before lock", int'(sFs), 0);
      check("R9 no slotStart before lock", int'(sSs), 0);
      check("R9 slave syncOut low", int'(sSync), 0);
    end
    slaveBit(1'b1, 1, 0, "R10 first edge");
    check("R10 slotStart on edge", int'(sSs), 1);
    slaveBit(1'b1, 0, 1, "R10 held high");
    for (int p = 2; p < 10; p++) slaveBit(1'b0, 0, p, "R10 count");
    slaveBit(1'b1, 1, 0, "R10 mid-frame resync");
    for (int p = 1; p < 16; p++) slaveBit(1'b0, 0, p, "R10 count after resync");
    slaveBit(1'b1, 1, 0, "R10 edge on wrap");
    check("R2 slotStart with frameStart", int'(sSs), 1);
    slaveBit(1'b0, 0, 1, "R10 no double after wrap");
  endtask

  task automatic t_slaveEarly();
    setCfg(15, 8, 8, 2, 2);
    restart(4'b1011);
    for (int i = 0; i < 3; i++) slaveBit(1'b0, 0, -1, "R9 early no lock");
    slaveBit(1'b1, 0, -1, "R11 edge bit is last");
    slaveBit(1'b0, 1, 0, "R11 next is bit0");
    slaveBit(1'b0, 0, 1, "R11 then bit1");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    setCfg(15, 8, 4, 2, 2);
    t_master(4'b0001, 15, 8, 0, 40, "R3 short late sync");
    t_master(4'b1001, 15, 8, 1, 40, "R4 short early sync");
    setCfg(23, 8, 8, 3, 3);
    t_master(4'b0101, 23, 8, 2, 50, "R5 long sync");
    t_master(4'b1101, 23, 8, 2, 30, "R5 long ignores early");
    t_disable();
    t_cfg();
    t_slaveLate();
    t_slaveEarly();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule